// File: doc/BRIEF.md
# Banked Index/Data Configuration Port

This block is a byte-wide configuration register file that a host reaches through two adjacent I/O addresses. The lower address is the index port: a write there latches an 8-bit register offset, and a read returns the offset held. The upper address is the data port: it reads or writes the register at the latched offset. A strap input picks which of two address pairs answers. Every other address is ignored.

The 256-byte offset space is split in two. Offsets 00h–2Fh are a global area that is the same whatever device is selected. It holds the device-select register at 07h and a read-only identification byte at 20h. Offsets 30h–FFh are banked. The device-select value, which is written through the same index/data pair, decides which logical device's 208-byte bank appears there. Each bank holds that device's settings, including its I/O base address registers, and the host can read them back. A select value with no bank behind it reads as FFh and drops writes. Host bus framing happens upstream of this block, which sees one decoded strobe per access.

Top module: `cfgport_top`

## Requirements
- R1: With `port_alt` low, the index port is at address 002Eh and the data port is at 002Fh.
- R2: With `port_alt` high, the index port is at 004Eh and the data port is at 004Fh. Addresses 002Eh and 002Fh are then ignored like any other address.
- R3: A write to the index port latches `io_wdata` as the current offset. A read of the index port returns that offset.
- R4: A data-port write at offset 07h loads the device-select register. A data-port read at offset 07h returns that register.
- R5: Global offsets 00h–2Fh, apart from 07h and 20h, are read/write bytes. Their contents do not depend on the device-select value.
- R6: Offset 20h reads as the fixed identification byte A5h. Writes to it have no effect.
- R7: Offsets 30h–FFh reach the bank of the device named by the device-select register, for select values 0 to 3. Each bank keeps its own contents.
- R8: When the device-select value is 4 or higher, data-port reads at offsets 30h–FFh return FFh and writes there change no bank.
- R9: A read strobe on an active port gives `rd_valid` high and the addressed byte on `rd_data` in the same cycle. The effect of a write is visible from the next cycle.
- R10: When there is no read strobe, or the address matches neither active port, `rd_data` is 00h and `rd_valid` is low. Writes to other addresses change nothing.
- R11: Reset clears the index, the device-select register and every storage byte to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Host I/O address of the current access |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write data |
| port_alt | input | 1 | Strap: 0 selects 002Eh/002Fh, 1 selects 004Eh/004Fh |
| rd_data | output | 8 | Read data, 00h unless a valid read is in progress |
| rd_valid | output | 1 | High when the read strobe hits an active port |

## Verification
The bench builds the block with its default parameters: four populated banks, banking from offset 30h, and A5h as the identification byte. With an 8-bit select register, this leaves 252 select values that have no bank. The bench uses 05h and FFh among them. It checks that writes made under those values leave every real bank untouched, and it drives both strap settings so that each address pair is exercised both while it is live and while it is dead.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        PORT_NONE  = 2'd0,
        PORT_INDEX = 2'd1,
        PORT_DATA  = 2'd2
    } port_e;

    typedef enum logic [1:0] {
        REG_SELECT = 2'd0,
        REG_IDENT  = 2'd1,
        REG_GLOBAL = 2'd2,
        REG_BANKED = 2'd3
    } region_e;

    typedef struct packed {
        port_e port;
        logic  wr;
        logic  rd;
        byte_t wdata;
    } host_req_t;

    // Maps an offset to the region that owns it.
    function automatic region_e reg_region(byte_t off, byte_t bank_lo,
                                           byte_t sel_off, byte_t id_off);
        if (off >= bank_lo)      return REG_BANKED;
        else if (off == sel_off) return REG_SELECT;
        else if (off == id_off)  return REG_IDENT;
        else                     return REG_GLOBAL;
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int           ADDR_W   = 16,
    parameter logic [15:0]  BASE_PRI = 16'h002E,
    parameter logic [15:0]  BASE_ALT = 16'h004E
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  byte_t             io_wdata,
    input  logic              port_alt,
    output host_req_t         req
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base      = port_alt ? BASE_ALT[ADDR_W-1:0] : BASE_PRI[ADDR_W-1:0];
        req.wr    = io_wr;
        req.rd    = io_rd;
        req.wdata = io_wdata;
        if (io_addr == base)
            req.port = PORT_INDEX;
        else if (io_addr == base + ADDR_W'(1))
            req.port = PORT_DATA;
        else
            req.port = PORT_NONE;
    end
endmodule

// File: rtl/cfgport_global.sv
module cfgport_global
    import cfgport_pkg::*;
#(
    parameter logic [7:0] BANK_LO = 8'h30,
    parameter logic [7:0] SEL_OFF = 8'h07,
    parameter logic [7:0] ID_OFF  = 8'h20,
    parameter logic [7:0] CHIP_ID = 8'hA5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  index_we,
    input  logic  data_we,
    input  byte_t wdata,
    output byte_t index_q,
    output byte_t dev_sel_q,
    output byte_t glob_rdata
);
    localparam int GDEPTH = int'(BANK_LO);
    localparam int GA_W   = $clog2(GDEPTH);

    byte_t   mem [GDEPTH];
    region_e region;

    always_comb region = reg_region(index_q, BANK_LO, SEL_OFF, ID_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q   <= '0;
            dev_sel_q <= '0;
        end else begin
            if (index_we)
                index_q <= wdata;
            if (data_we && region == REG_SELECT)
                dev_sel_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GDEPTH; i++) mem[i] <= '0;
        end else if (data_we && region == REG_GLOBAL) begin
            mem[index_q[GA_W-1:0]] <= wdata;
        end
    end

    always_comb begin
        case (region)
            REG_SELECT: glob_rdata = dev_sel_q;
            REG_IDENT:  glob_rdata = CHIP_ID;
            REG_GLOBAL: glob_rdata = mem[index_q[GA_W-1:0]];
            default:    glob_rdata = '0;
        endcase
    end

    // R3: an index-port write is what the index holds next cycle
    p_idx_load_r3: assert property (@(posedge clk) disable iff (rst)
        index_we |=> index_q == $past(wdata));

    // R4: a data write at the select offset loads the select register
    p_sel_load_r4: assert property (@(posedge clk) disable iff (rst)
        (data_we && index_q == SEL_OFF && !index_we) |=> dev_sel_q == $past(wdata));

    // R4: the select register moves only through its own offset
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(data_we && index_q == SEL_OFF) |=> $stable(dev_sel_q));
endmodule

// File: rtl/cfgport_banks.sv
module cfgport_banks
    import cfgport_pkg::*;
#(
    parameter int         NUM_DEV = 4,
    parameter logic [7:0] BANK_LO = 8'h30
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bank_we,
    input  byte_t dev_sel,
    input  byte_t offset,
    input  byte_t wdata,
    output byte_t rd_byte
);
    localparam int    DEPTH   = 256 - int'(BANK_LO);
    localparam int    AW      = $clog2(DEPTH);
    localparam byte_t EMPTY_B = 8'hFF;

    logic [AW-1:0] loc;
    logic          sel_ok;
    logic [NUM_DEV-1:0] we_vec;
    byte_t         rd_vec [NUM_DEV];

    always_comb begin
        byte_t diff;
        diff   = offset - BANK_LO;
        loc    = diff[AW-1:0];
        sel_ok = int'(dev_sel) < NUM_DEV;
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
        byte_t mem [DEPTH];

        assign we_vec[d] = bank_we && sel_ok && (int'(dev_sel) == d);
        assign rd_vec[d] = mem[loc];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we_vec[d]) begin
                mem[loc] <= wdata;
            end
        end
    end

    always_comb begin
        rd_byte = EMPTY_B;
        for (int d = 0; d < NUM_DEV; d++)
            if (sel_ok && int'(dev_sel) == d) rd_byte = rd_vec[d];
    end

    // R7: a bank write lands in at most one bank
    p_one_bank_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_vec));

    // R8: a select value without a bank enables no bank
    p_empty_nowr_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(dev_sel) >= NUM_DEV) |-> we_vec == '0);
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] BASE_PRI = 16'h002E,
    parameter logic [15:0] BASE_ALT = 16'h004E,
    parameter int          NUM_DEV  = 4,
    parameter logic [7:0]  BANK_LO  = 8'h30,
    parameter logic [7:0]  SEL_OFF  = 8'h07,
    parameter logic [7:0]  ID_OFF   = 8'h20,
    parameter logic [7:0]  CHIP_ID  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    input  logic              port_alt,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    host_req_t req;
    byte_t     index_q, dev_sel_q, glob_rdata, bank_rdata, mux_data;
    logic      index_we, data_we, bank_we;
    region_e   region;

    cfgport_decode #(
        .ADDR_W  (ADDR_W),
        .BASE_PRI(BASE_PRI),
        .BASE_ALT(BASE_ALT)
    ) u_decode (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_wdata(io_wdata),
        .port_alt(port_alt),
        .req     (req)
    );

    always_comb begin
        region   = reg_region(index_q, BANK_LO, SEL_OFF, ID_OFF);
        index_we = req.wr && req.port == PORT_INDEX;
        data_we  = req.wr && req.port == PORT_DATA;
        bank_we  = data_we && region == REG_BANKED;
    end

    cfgport_global #(
        .BANK_LO(BANK_LO),
        .SEL_OFF(SEL_OFF),
        .ID_OFF (ID_OFF),
        .CHIP_ID(CHIP_ID)
    ) u_global (
        .clk       (clk),
        .rst       (rst),
        .index_we  (index_we),
        .data_we   (data_we),
        .wdata     (req.wdata),
        .index_q   (index_q),
        .dev_sel_q (dev_sel_q),
        .glob_rdata(glob_rdata)
    );

    cfgport_banks #(
        .NUM_DEV(NUM_DEV),
        .BANK_LO(BANK_LO)
    ) u_banks (
        .clk    (clk),
        .rst    (rst),
        .bank_we(bank_we),
        .dev_sel(dev_sel_q),
        .offset (index_q),
        .wdata  (req.wdata),
        .rd_byte(bank_rdata)
    );

    always_comb begin
        case (req.port)
            PORT_INDEX: mux_data = index_q;
            PORT_DATA:  mux_data = (region == REG_BANKED) ? bank_rdata : glob_rdata;
            default:    mux_data = '0;
        endcase
        rd_valid = req.rd && req.port != PORT_NONE;
        rd_data  = rd_valid ? mux_data : '0;
    end

    // Checker-side view of which address pair is live
    logic [ADDR_W-1:0] chk_base;
    logic              chk_hit;
    always_comb begin
        chk_base = port_alt ? BASE_ALT[ADDR_W-1:0] : BASE_PRI[ADDR_W-1:0];
        chk_hit  = (io_addr == chk_base) || (io_addr == chk_base + ADDR_W'(1));
    end

    // R10: an access off the live pair stays silent
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && chk_hit) |-> (rd_data == 8'h00 && !rd_valid));

    // R9: a read on the live pair is valid in the same cycle
    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (io_rd && chk_hit) |-> rd_valid);

    // R6: the identification offset always reads the fixed byte
    p_ident_r6: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == chk_base + ADDR_W'(1) && index_q == ID_OFF)
            |-> rd_data == CHIP_ID);

    // R8: banked reads under an empty select value give FFh
    p_empty_rd_r8: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == chk_base + ADDR_W'(1) && index_q >= BANK_LO
         && int'(dev_sel_q) >= NUM_DEV) |-> rd_data == 8'hFF);
endmodule

// File: tb/cfgport_top_tb_top.sv
module cfgport_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] io_addr;
    logic        io_wr, io_rd, port_alt;
    logic [7:0]  io_wdata;
    logic [7:0]  rd_data;
    logic        rd_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_glob [48];
    logic [7:0] m_bank [4][208];
    logic [7:0] m_idx, m_sel;

    always #10 clk = ~clk;

    cfgport_top dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .port_alt(port_alt), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic int port_kind(logic [15:0] a);
        logic [15:0] b;
        b = port_alt ? 16'h004E : 16'h002E;
        if (a == b) return 1;
        if (a == b + 16'd1) return 2;
        return 0;
    endfunction

    function automatic logic [7:0] model_read();
        if (m_idx >= 8'h30) return (m_sel < 8'd4) ? m_bank[m_sel][m_idx - 8'h30] : 8'hFF;
        if (m_idx == 8'h07) return m_sel;
        if (m_idx == 8'h20) return 8'hA5;
        return m_glob[m_idx];
    endfunction

    task automatic model_reset();
        m_idx = 0; m_sel = 0;
        for (int i = 0; i < 48; i++) m_glob[i] = 0;
        for (int d = 0; d < 4; d++)
            for (int i = 0; i < 208; i++) m_bank[d][i] = 0;
    endtask

    // One bus cycle: drive at the falling edge, compare, then update the model.
    task automatic cyc(input logic [15:0] a, input logic w, input logic r,
                       input logic [7:0] wd, input string tag);
        int k;
        logic [7:0] exp_d;
        logic exp_v;
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = r; io_wdata = wd;
        #2;
        k = port_kind(a);
        exp_v = r && (k != 0);
        exp_d = !exp_v ? 8'h00 : (k == 1) ? m_idx : model_read();
        checks++;
        if (rd_valid !== exp_v || rd_data !== exp_d) begin
            failures++;
            $display("FAIL %s addr=%h: got valid=%b data=%h, expected valid=%b data=%h",
                     tag, a, rd_valid, rd_data, exp_v, exp_d);
        end
        if (w && k == 1) m_idx = wd;
        else if (w && k == 2) begin
            if (m_idx >= 8'h30) begin
                if (m_sel < 8'd4) m_bank[m_sel][m_idx - 8'h30] = wd;
            end else if (m_idx == 8'h07) m_sel = wd;
            else if (m_idx != 8'h20) m_glob[m_idx] = wd;
        end
    endtask

    task automatic wr_reg(input logic [7:0] off, input logic [7:0] v, input string tag);
        logic [15:0] b;
        b = port_alt ? 16'h004E : 16'h002E;
        cyc(b, 1, 0, off, tag);
        cyc(b + 16'd1, 1, 0, v, tag);
    endtask

    task automatic rd_reg(input logic [7:0] off, input string tag);
        logic [15:0] b;
        b = port_alt ? 16'h004E : 16'h002E;
        cyc(b, 1, 0, off, tag);
        cyc(b, 0, 1, 0, tag);
        cyc(b + 16'd1, 0, 1, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; io_addr = 0; io_wr = 0; io_rd = 0; io_wdata = 0; port_alt = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R11: reset contents
        cyc(16'h002E, 0, 1, 0, "R11");
        cyc(16'h002F, 0, 1, 0, "R11");
        rd_reg(8'h07, "R11");
        rd_reg(8'h30, "R11");
        rd_reg(8'hFF, "R11");
        rd_reg(8'h15, "R11");

        // R1 / R3: index latch and readback on the default pair
        cyc(16'h002E, 1, 0, 8'h5A, "R3");
        cyc(16'h002E, 0, 1, 0, "R3");
        cyc(16'h002E, 0, 1, 0, "R1");

        // R5: global storage
        wr_reg(8'h00, 8'h11, "R5");
        wr_reg(8'h10, 8'h3C, "R5");
        wr_reg(8'h2F, 8'hC3, "R5");
        rd_reg(8'h00, "R5");
        rd_reg(8'h10, "R5");
        rd_reg(8'h2F, "R5");

        // R6: identification byte
        rd_reg(8'h20, "R6");
        wr_reg(8'h20, 8'h00, "R6");
        rd_reg(8'h20, "R6");

        // R4 / R7: select each bank and fill distinct values
        for (int d = 0; d < 4; d++) begin
            wr_reg(8'h07, 8'(d), "R4");
            rd_reg(8'h07, "R4");
            wr_reg(8'h30, 8'(8'h40 + d), "R7");
            wr_reg(8'h60, 8'(8'h80 + d), "R7");
            wr_reg(8'hFF, 8'(8'hE0 + d), "R7");
        end
        for (int d = 0; d < 4; d++) begin
            wr_reg(8'h07, 8'(d), "R7");
            rd_reg(8'h30, "R7");
            rd_reg(8'h60, "R7");
            rd_reg(8'hFF, "R7");
            rd_reg(8'h10, "R5");
        end

        // R8: select values without a bank
        wr_reg(8'h07, 8'h05, "R8");
        rd_reg(8'h30, "R8");
        wr_reg(8'h30, 8'h77, "R8");
        rd_reg(8'hFF, "R8");
        wr_reg(8'h07, 8'hFF, "R8");
        wr_reg(8'h60, 8'h66, "R8");
        rd_reg(8'h60, "R8");
        for (int d = 0; d < 4; d++) begin
            wr_reg(8'h07, 8'(d), "R8");
            rd_reg(8'h30, "R8");
            rd_reg(8'h60, "R8");
        end

        // R9: read right after write in back-to-back cycles
        wr_reg(8'h12, 8'h9D, "R9");
        cyc(16'h002F, 0, 1, 0, "R9");
        cyc(16'h002F, 1, 0, 8'h4B, "R9");
        cyc(16'h002F, 0, 1, 0, "R9");

        // R10: other addresses are ignored
        cyc(16'h002D, 1, 0, 8'h33, "R10");
        cyc(16'h0030, 1, 0, 8'h44, "R10");
        cyc(16'h004E, 1, 0, 8'h07, "R10");
        cyc(16'h004F, 1, 0, 8'h02, "R10");
        cyc(16'h0080, 0, 1, 0, "R10");
        cyc(16'h012E, 0, 1, 0, "R10");
        cyc(16'h002E, 0, 1, 0, "R10");
        cyc(16'h002F, 0, 1, 0, "R10");
        cyc(16'h002F, 0, 0, 0, "R10");

        // R2: move to the alternate pair
        port_alt = 1;
        cyc(16'h002E, 0, 1, 0, "R2");
        cyc(16'h002F, 1, 0, 8'hAA, "R2");
        cyc(16'h002E, 1, 0, 8'h10, "R2");
        cyc(16'h004E, 0, 1, 0, "R2");
        rd_reg(8'h10, "R2");
        rd_reg(8'h12, "R2");
        wr_reg(8'h07, 8'h02, "R2");
        rd_reg(8'h60, "R2");
        wr_reg(8'h25, 8'h5E, "R2");
        rd_reg(8'h25, "R2");

        port_alt = 0;
        cyc(16'h004F, 0, 1, 0, "R2");
        rd_reg(8'h25, "R1");

        // R11: reset again clears everything
        @(negedge clk); rst = 1; io_wr = 0; io_rd = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        model_reset();
        rd_reg(8'h07, "R11");
        rd_reg(8'h10, "R11");
        rd_reg(8'h30, "R11");

        @(negedge clk); io_wr = 0; io_rd = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule